// File: doc/BRIEF.md
# USB Bus Reset and High-Speed Chirp Detector

This block watches the decoded line state of a USB device port and decides when the host is signalling a bus reset. A reset is recognised from the length of an unbroken SE0 run. The run must be short in full-speed operation and much longer in high-speed operation, where the long wait separates a reset from a suspend. Once it recognises a reset, the block raises a bus-reset flag. It also gives a one-cycle pulse that other logic uses to return the device to its Default state.

After recognition the block runs the device side of the high-speed detection handshake. It requests a Chirp-K drive for a fixed time and then watches the line for the host's alternating K-J chirps. The flag falls either when a complete host chirp sequence is seen or when a timeout ends the wait. A result bit records which of the two happened. All timing comes from counting clock cycles, and every duration is a parameter in cycles.

Top module: `usb_bus_reset_detect`

## Requirements
- R1: In full-speed mode (`hsMode`=0), once `lineState` has been SE0 (2'b00) for FS_SE0_CYC consecutive samples, `resetFlag` rises on the following clock edge.
- R2: In high-speed mode (`hsMode`=1) the SE0 run must reach HS_SE0_CYC samples. A shorter SE0 run raises no flag, even when it is longer than FS_SE0_CYC.
- R3: Any line state other than SE0 (J=2'b01, K=2'b10, SE1=2'b11) before the threshold clears the SE0 timer. The next SE0 run then starts counting from zero.
- R4: `chirpKDrive` is high for exactly CHIRP_CYC cycles, starting in the same cycle that `resetFlag` rises.
- R5: After the chirp, SEQ_LEN alternating host runs that start with K and each last at least STABLE_CYC samples make `resetFlag` fall with `hsGranted`=1.
- R6: A host line run shorter than STABLE_CYC samples clears the count of host chirps already seen.
- R7: If no complete host sequence arrives, `resetFlag` falls exactly WAIT_CYC cycles after `chirpKDrive` falls, with `hsGranted`=0. The flag is therefore high for CHIRP_CYC+WAIT_CYC cycles.
- R8: `hsGranted` clears when `resetFlag` rises, takes its result when `resetFlag` falls, and does not change while the flag stays low.
- R9: `defaultPulse` is high for exactly one cycle, the cycle in which `resetFlag` rises.
- R10: After `resetFlag` falls, no new reset is recognised until the line has left SE0 at least once.
- R11: While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rstN | input | 1 | Active-low synchronous reset |
| lineState | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 SE1 |
| hsMode | input | 1 | 1 while the port operates in high-speed mode |
| resetFlag | output | 1 | Bus reset in progress |
| chirpKDrive | output | 1 | Request to drive Chirp-K on the bus |
| hsGranted | output | 1 | 1 if the host chirp sequence was seen; valid once the flag falls |
| defaultPulse | output | 1 | One-cycle pulse telling other logic to return to the Default state |

## Verification
The embedded assertions check on every cycle that the flag rises only after an SE0 sample and that the Default pulse coincides with the rise. They also check that the chirp request ends with the flag still high, that the result bit holds still while the flag is low, and that the host chirp count never exceeds its bound. The exact thresholds in both speed modes and the timer restart after a broken SE0 run can only be shown by the bench scenarios. The same holds for the cycle-exact chirp and timeout lengths, the grant after a clean host sequence, the loss of progress after a short glitch, and the rearm rule after a reset that stays in SE0.

// File: rtl/usb_rst_pkg.sv
package usb_rst_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } lineState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSe0;     // hold the SE0 run timer at zero
    logic clrPhase;   // restart the chirp / wait phase timer
    logic hostWatch;  // host chirp recognizer active (cleared when low)
  } strobes_t;

endpackage

// File: rtl/reset_timer_dp.sv
module reset_timer_dp
  import usb_rst_pkg::*;
#(
  parameter int FS_SE0_CYC = 150,
  parameter int HS_SE0_CYC = 180000,
  parameter int CHIRP_CYC  = 90000,
  parameter int WAIT_CYC   = 120000,
  parameter int STABLE_CYC = 150,
  parameter int SEQ_LEN    = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  lineState_t line,
  input  strobes_t   st,
  output logic       se0FsHit,
  output logic       se0HsHit,
  output logic       chirpDone,
  output logic       waitDone,
  output logic       seqDone
);

  localparam int SE0_MAX = (HS_SE0_CYC > FS_SE0_CYC) ? HS_SE0_CYC : FS_SE0_CYC;
  localparam int SE0_W   = $clog2(SE0_MAX + 1);
  localparam int PH_MAX  = (CHIRP_CYC > WAIT_CYC) ? CHIRP_CYC : WAIT_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int RUN_W   = $clog2(STABLE_CYC + 1);
  localparam int SEQ_W   = $clog2(SEQ_LEN + 1);

  logic [SE0_W-1:0] se0Cnt;
  logic [PH_W-1:0]  phaseCnt;
  logic [RUN_W-1:0] runLen;
  logic [SEQ_W-1:0] chirpCnt;
  lineState_t       prevLine;
  lineState_t       expectLine;

  // SE0 run timer, saturating
  always_ff @(posedge clk) begin
    if (!rstN || st.clrSe0 || line != LS_SE0) se0Cnt <= '0;
    else if (se0Cnt != SE0_W'(SE0_MAX))       se0Cnt <= se0Cnt + SE0_W'(1);
  end

  assign se0FsHit = se0Cnt >= SE0_W'(FS_SE0_CYC);
  assign se0HsHit = se0Cnt >= SE0_W'(HS_SE0_CYC);

  // phase timer for chirp drive and host wait
  always_ff @(posedge clk) begin
    if (!rstN || st.clrPhase)           phaseCnt <= '0;
    else if (phaseCnt != PH_W'(PH_MAX)) phaseCnt <= phaseCnt + PH_W'(1);
  end

  assign chirpDone = phaseCnt == PH_W'(CHIRP_CYC - 1);
  assign waitDone  = phaseCnt == PH_W'(WAIT_CYC - 1);

  // host chirp recognizer
  assign expectLine = chirpCnt[0] ? LS_J : LS_K;

  always_ff @(posedge clk) begin
    if (!rstN || !st.hostWatch) begin
      runLen   <= '0;
      chirpCnt <= '0;
      prevLine <= LS_SE0;
    end else if (line != prevLine) begin
      prevLine <= line;
      runLen   <= RUN_W'(1);
      if (runLen != '0 && runLen < RUN_W'(STABLE_CYC)) chirpCnt <= '0;  // glitch
    end else begin
      if (runLen != RUN_W'(STABLE_CYC)) runLen <= runLen + RUN_W'(1);
      if (runLen == RUN_W'(STABLE_CYC - 1)) begin
        if (line == expectLine) begin
          if (chirpCnt != SEQ_W'(SEQ_LEN)) chirpCnt <= chirpCnt + SEQ_W'(1);
        end else if (line == LS_K) chirpCnt <= SEQ_W'(1);
        else                       chirpCnt <= '0;
      end
    end
  end

  assign seqDone = chirpCnt == SEQ_W'(SEQ_LEN);

  // R5: the host chirp count never passes the sequence length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    chirpCnt <= SEQ_W'(SEQ_LEN));

  // R6: a short run always wipes the progress on the next sample
  a_r6_glitch_clears: assert property (@(posedge clk) disable iff (!rstN)
    (st.hostWatch && line != prevLine && runLen != '0 && runLen < RUN_W'(STABLE_CYC))
    |=> (chirpCnt == '0 || !st.hostWatch));

endmodule

// File: rtl/reset_chirp_ctrl.sv
module reset_chirp_ctrl
  import usb_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lineState_t line,
  input  logic       hsMode,
  input  logic       se0FsHit,
  input  logic       se0HsHit,
  input  logic       chirpDone,
  input  logic       waitDone,
  input  logic       seqDone,
  output strobes_t   st,
  output logic       resetFlag,
  output logic       chirpKDrive,
  output logic       hsGranted,
  output logic       defaultPulse
);

  typedef enum logic [1:0] {S_IDLE, S_CHIRP, S_WAIT, S_REARM} state_t;

  state_t state, stateNx;
  logic   se0Hit;

  assign se0Hit = hsMode ? se0HsHit : se0FsHit;

  always_comb begin
    stateNx     = state;
    st.clrSe0   = (state != S_IDLE);
    st.clrPhase = 1'b0;
    st.hostWatch = (state == S_WAIT);
    unique case (state)
      S_IDLE:  if (se0Hit) begin stateNx = S_CHIRP; st.clrPhase = 1'b1; end
      S_CHIRP: if (chirpDone) begin stateNx = S_WAIT; st.clrPhase = 1'b1; end
      S_WAIT:  if (seqDone || waitDone) stateNx = S_REARM;
      S_REARM: if (line != LS_SE0) stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      hsGranted    <= 1'b0;
      defaultPulse <= 1'b0;
    end else begin
      state        <= stateNx;
      defaultPulse <= (state == S_IDLE) && se0Hit;
      if (state == S_IDLE && se0Hit) hsGranted <= 1'b0;
      else if (state == S_WAIT && seqDone) hsGranted <= 1'b1;
      else if (state == S_WAIT && waitDone) hsGranted <= 1'b0;
    end
  end

  assign resetFlag   = (state == S_CHIRP) || (state == S_WAIT);
  assign chirpKDrive = (state == S_CHIRP);

  // R1: a rising flag is always preceded by a counted SE0 sample
  a_r1_rise_after_se0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetFlag) |-> $past(line, 2) == LS_SE0);

  // R9: the Default pulse marks the rise of the flag
  a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    defaultPulse |-> $rose(resetFlag));

  // R7: the chirp ends into the host wait, never straight to idle
  a_r7_chirp_then_wait: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chirpKDrive) |-> resetFlag);

  // R8: the result holds while the flag stays low
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!resetFlag && !$past(resetFlag)) |-> $stable(hsGranted));

endmodule

// File: rtl/usb_bus_reset_detect.sv
module usb_bus_reset_detect
  import usb_rst_pkg::*;
#(
  parameter int FS_SE0_CYC = 150,
  parameter int HS_SE0_CYC = 180000,
  parameter int CHIRP_CYC  = 90000,
  parameter int WAIT_CYC   = 120000,
  parameter int STABLE_CYC = 150,
  parameter int SEQ_LEN    = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lineState,
  input  logic       hsMode,
  output logic       resetFlag,
  output logic       chirpKDrive,
  output logic       hsGranted,
  output logic       defaultPulse
);

  lineState_t line;
  strobes_t   st;
  logic       se0FsHit, se0HsHit, chirpDone, waitDone, seqDone;

  assign line = lineState_t'(lineState);

  reset_timer_dp #(
    .FS_SE0_CYC(FS_SE0_CYC), .HS_SE0_CYC(HS_SE0_CYC), .CHIRP_CYC(CHIRP_CYC),
    .WAIT_CYC(WAIT_CYC), .STABLE_CYC(STABLE_CYC), .SEQ_LEN(SEQ_LEN)
  ) i_dp (
    .clk(clk), .rstN(rstN), .line(line), .st(st),
    .se0FsHit(se0FsHit), .se0HsHit(se0HsHit),
    .chirpDone(chirpDone), .waitDone(waitDone), .seqDone(seqDone)
  );

  reset_chirp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .line(line), .hsMode(hsMode),
    .se0FsHit(se0FsHit), .se0HsHit(se0HsHit),
    .chirpDone(chirpDone), .waitDone(waitDone), .seqDone(seqDone),
    .st(st), .resetFlag(resetFlag), .chirpKDrive(chirpKDrive),
    .hsGranted(hsGranted), .defaultPulse(defaultPulse)
  );

endmodule

// File: tb/test_usb_bus_reset_detect.sv
module test_usb_bus_reset_detect;

  localparam int FS  = 10;
  localparam int HS  = 60;
  localparam int CH  = 40;
  localparam int WT  = 300;
  localparam int STB = 8;
  localparam int SEQ = 6;
  localparam logic [1:0] SE0 = 2'b00, JS = 2'b01, KS = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] lineState = JS;
  logic hsMode = 1'b0;
  logic resetFlag, chirpKDrive, hsGranted, defaultPulse;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usb_bus_reset_detect #(
    .FS_SE0_CYC(FS), .HS_SE0_CYC(HS), .CHIRP_CYC(CH),
    .WAIT_CYC(WT), .STABLE_CYC(STB), .SEQ_LEN(SEQ)
  ) i_usb_bus_reset_detect (
    .clk(clk), .rstN(rstN), .lineState(lineState), .hsMode(hsMode),
    .resetFlag(resetFlag), .chirpKDrive(chirpKDrive),
    .hsGranted(hsGranted), .defaultPulse(defaultPulse)
  );

  function automatic bit expectDetect(int len, bit hs);
    return len >= (hs ? HS : FS);
  endfunction

  function automatic int expectRise(bit hs);
    return (hs ? HS : FS) + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(logic [1:0] ls, int n);
    lineState = ls;
    repeat (n) @(negedge clk);
  endtask

  // drive SE0 and count samples until the flag rises (0 = none within limit)
  task automatic detectRise(int limit, output int n);
    lineState = SE0;
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (resetFlag) begin n = i; break; end
    end
  endtask

  // from the rise sample, count flag, chirp and pulse samples until the fall
  task automatic measure(output int flagLen, output int chirpLen, output int pulses);
    flagLen = 0; chirpLen = 0; pulses = 0;
    for (int i = 0; i < 3000; i++) begin
      if (!resetFlag) break;
      flagLen++;
      if (chirpKDrive) chirpLen++;
      if (defaultPulse) pulses++;
      @(negedge clk);
    end
  endtask

  task automatic waitChirpEnd();
    for (int i = 0; i < 3000; i++) begin
      if (!chirpKDrive) break;
      @(negedge clk);
    end
  endtask

  task automatic waitFall();
    for (int i = 0; i < 3000; i++) begin
      if (!resetFlag) break;
      @(negedge clk);
    end
  endtask

  task automatic hostSeq(int runLen);
    for (int r = 0; r < SEQ; r++) hold((r % 2 == 0) ? KS : JS, runLen);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    int n, fl, cl, pu;
    void'($urandom(32'd4242));

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 flag", resetFlag, 0);
    chk("R11 chirp", chirpKDrive, 0);
    chk("R11 grant", hsGranted, 0);
    chk("R11 pulse", defaultPulse, 0);
    rstN = 1'b1;
    hold(JS, 3);

    // R1 full-speed threshold, R4 chirp, R9 pulse, R7 timeout
    hsMode = 1'b0;
    detectRise(200, n);
    chk("R1 rise sample", n, expectRise(0));
    measure(fl, cl, pu);
    chk("R4 chirp length", cl, CH);
    chk("R9 pulse count", pu, 1);
    chk("R7 flag length", fl, CH + WT);
    chk("R7 grant", hsGranted, 0);

    // R10: still SE0 after the fall, no new detection
    hold(SE0, 3 * FS);
    chk("R10 no retrigger", resetFlag, 0);
    hold(JS, 2);

    // R3: broken SE0 runs restart the timer
    hold(SE0, FS - 1);
    hold(JS, 1);
    hold(SE0, FS - 1);
    hold(KS, 1);
    chk("R3 no flag", resetFlag, 0);
    detectRise(200, n);
    chk("R3 restart", n, expectRise(0));
    lineState = JS;
    waitFall();
    hold(JS, 2);

    // R2: high-speed needs the long run
    hsMode = 1'b1;
    hold(SE0, FS + 5);
    hold(JS, 2);
    chk("R2 short SE0", resetFlag, 0);
    detectRise(200, n);
    chk("R2 rise sample", n, expectRise(1));
    chk("R8 grant cleared", hsGranted, 0);
    waitChirpEnd();
    hostSeq(STB + 4);
    hold(JS, 2);
    chk("R5 flag down", resetFlag, 0);
    chk("R5 granted", hsGranted, 1);
    hold(JS, 5);
    chk("R8 grant holds", hsGranted, 1);

    // R6: glitch wipes progress, so the wait times out
    hsMode = 1'b0;
    detectRise(200, n);
    chk("R8 grant cleared on rise", hsGranted, 0);
    waitChirpEnd();
    hold(KS, 12); hold(JS, 12); hold(KS, 12);
    hold(SE0, 3);
    hold(JS, 12); hold(KS, 12); hold(JS, 12);
    hold(JS, 1);
    chk("R6 still waiting", resetFlag, 1);
    waitFall();
    chk("R6 not granted", hsGranted, 0);
    hold(JS, 2);

    // random SE0 lengths and host behaviour
    for (int t = 0; t < 16; t++) begin
      bit hs, seen, good;
      int thr, len;
      hs = 1'($urandom % 2);
      hsMode = hs;
      thr = hs ? HS : FS;
      len = 1 + int'($urandom % (2 * thr));
      good = 1'($urandom % 2);
      seen = 0;
      lineState = SE0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (resetFlag) seen = 1;
      end
      lineState = JS;
      repeat (2) begin
        @(negedge clk);
        if (resetFlag) seen = 1;
      end
      chk(hs ? "R2 random" : "R1 random", seen, expectDetect(len, hs));
      if (seen) begin
        waitChirpEnd();
        if (good)
          for (int r = 0; r < SEQ; r++)
            hold((r % 2 == 0) ? KS : JS, STB + int'($urandom % 7));
        lineState = JS;
        waitFall();
        chk(good ? "R5 random" : "R7 random", hsGranted, good);
      end
      hold(JS, 2);
    end

    finished = 1;
    summary();
  end

endmodule